// File: doc/BRIEF.md
# Software-Pipelined Loop Branch Controller

This block is the hardware side of kernel-only software pipelining. A compiler emits a single copy of the loop kernel. Each operation in that kernel is guarded by a staging predicate, and the kernel ends with one special loop-back branch. The controller holds these pieces of state:

- an iteration counter;
- a drain-stage counter;
- a rotation base;
- a small file of staging predicates, renamed through the rotation base.

Each time the branch is executed, the controller decides whether to loop again. It also shifts the predicate window by one place. Stage k of the kernel is guarded by logical predicate k-1.

The loop runs in two phases. While iterations remain, every taken branch feeds a 1 into logical predicate 0. This fills the pipeline one stage at a time. Once the iteration counter reaches zero, the controller keeps branching for the programmed number of drain stages and feeds in 0s instead. The stages then switch off one by one, so no separate epilog code is needed. When both counters are zero, the branch falls through and a one-cycle done pulse is raised.

The loop is set up by an initialise command. It carries the iteration count and the stage count, both in zero-relative form (N-1 and S-1).

Top module: `swp_loop_branch`

## Requirements
- R1: One cycle after `init_valid`, the following state holds. The iteration counter holds `init_iters` and the drain counter holds `init_stages`. `rrb` reads 0. Every predicate is cleared except logical P[0], so `pred_vec` equals 1. `br_taken` and `loop_done` are low.
- R2: When `init_valid` and `br_valid` are high in the same cycle, the initialise command wins and the branch strobe has no effect.
- R3: A branch with the iteration counter non-zero is a fill step. It decrements the iteration counter and writes 1 into logical P[0]. One cycle later, `br_taken` is 1.
- R4: A branch with the iteration counter at zero and the drain counter non-zero is a drain step. It decrements the drain counter and writes 0 into logical P[0]. One cycle later, `br_taken` is 1.
- R5: A branch with both counters at zero falls through. One cycle later, `br_taken` is 0 and `loop_done` is 1. `loop_done` stays high for that one cycle only.
- R6: Each taken branch does two things. First, it decrements `rrb` modulo P_SIZE. Second, it renames the predicates: new `pred_vec[i+1]` equals old `pred_vec[i]`, and the old top bit is dropped. `pred_vec` bit i is logical P[i], which is held in physical entry (i + rrb) mod P_SIZE.
- R7: In two cases a branch strobe is ignored: before any initialise command after reset, and after the fall-through branch until the next initialise. In those cases `br_taken` and `loop_done` stay 0, and `pred_vec` and `rrb` hold their values.
- R8: A loop of N iterations and S stages produces N+S-2 taken branches followed by one fall-through, so the kernel runs N+S-1 times. For N=4 and S=4, `pred_vec[3:0]` reads 0001, 0011, 0111, 1111, 1110, 1100, 1000 after the initialise and each following taken branch. Written MSB first, this is logical P[0..3] = 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R9: `br_taken` and `loop_done` are registered. They describe the strobe of the previous cycle and are 0 in any cycle that follows a cycle without a strobe.
- R10: After reset, `br_taken`, `loop_done`, `pred_vec` and `rrb` are all 0, and the controller is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Initialise command strobe |
| init_iters | input | CNT_W | Iteration count minus one |
| init_stages | input | CNT_W | Stage count minus one |
| br_valid | input | 1 | Loop-back branch execute strobe |
| br_taken | output | 1 | Branch taken, for the previous cycle's strobe |
| pred_vec | output | P_SIZE | Staging predicates in logical order (bit i = P[i]) |
| rrb | output | $clog2(P_SIZE) | Current rotation base |
| loop_done | output | 1 | One-cycle pulse on the fall-through branch |

## Verification
The bench targets these corner cases, each with the fault it would expose:

- **Single-iteration, single-stage loop.** Here the very first branch must fall through. A controller that tested its counters after decrementing them would instead take the branch once.
- **Loop long enough to wrap the rotation base past zero.** If the physical index were not taken modulo the file size, bits would appear at the wrong logical positions.
- **Strobes before initialisation, after exit, and together with an initialise command.** A controller that lost its armed state, or let the branch win over initialise, would report spurious taken branches or corrupt the freshly cleared predicates.
- **The fixed 4-by-4 sequence.** This catches a drain phase that feeds in 1s, or one that runs one stage too many or too few.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // Outcome of one cycle's branch decision.
  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,  // no strobe, or strobe overridden by initialise
    BK_IGNORE = 3'd1,  // strobe while not armed
    BK_FILL   = 3'd2,  // iterations remain: rotate a 1 in
    BK_DRAIN  = 3'd3,  // draining stages: rotate a 0 in
    BK_EXIT   = 3'd4   // both counters exhausted: fall through
  } br_kind_e;

  function automatic logic kind_rotates(br_kind_e k);
    return (k == BK_FILL) || (k == BK_DRAIN);
  endfunction

  function automatic logic kind_fill_bit(br_kind_e k);
    return (k == BK_FILL);
  endfunction

endpackage

// File: rtl/swp_stage_counters.sv
module swp_stage_counters
  import swp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_valid,
  input  logic [CNT_W-1:0] init_iters,
  input  logic [CNT_W-1:0] init_stages,
  input  logic             br_valid,
  output br_kind_e         kind,
  output logic             armed,
  output logic             lc_nonzero,
  output logic             esc_nonzero
);

  logic [CNT_W-1:0] lc_q;
  logic [CNT_W-1:0] esc_q;
  logic             armed_q;

  function automatic logic [CNT_W-1:0] count_down(logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic br_kind_e classify(logic init, logic br, logic arm,
                                        logic lc_nz, logic esc_nz);
    if (!br || init) return BK_IDLE;
    if (!arm)        return BK_IGNORE;
    if (lc_nz)       return BK_FILL;
    if (esc_nz)      return BK_DRAIN;
    return BK_EXIT;
  endfunction

  assign lc_nonzero  = (lc_q != '0);
  assign esc_nonzero = (esc_q != '0);
  assign armed       = armed_q;
  assign kind        = classify(init_valid, br_valid, armed_q, lc_nonzero, esc_nonzero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_q    <= '0;
      esc_q   <= '0;
      armed_q <= 1'b0;
    end else if (init_valid) begin
      lc_q    <= init_iters;
      esc_q   <= init_stages;
      armed_q <= 1'b1;
    end else begin
      unique case (kind)
        BK_FILL:  lc_q    <= count_down(lc_q);
        BK_DRAIN: esc_q   <= count_down(esc_q);
        BK_EXIT:  armed_q <= 1'b0;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/swp_rot_pred_file.sv
module swp_rot_pred_file #(
  parameter int P_SIZE = 8,
  localparam int RRB_W = $clog2(P_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              fill_bit,
  output logic [RRB_W-1:0]  rrb,
  output logic [P_SIZE-1:0] pred_vec
);

  logic [P_SIZE-1:0] phys_q;
  logic [RRB_W-1:0]  rrb_q;
  logic [RRB_W-1:0]  wr_idx;

  // Logical-to-physical mapping; P_SIZE is a power of two so the sum wraps.
  function automatic logic [RRB_W-1:0] phys_of(logic [RRB_W-1:0] base, int unsigned lidx);
    return base + RRB_W'(lidx);
  endfunction

  function automatic logic [RRB_W-1:0] base_dec(logic [RRB_W-1:0] base);
    return base - RRB_W'(1);
  endfunction

  // After the base drops by one, new logical P[0] lives at physical base-1.
  assign wr_idx = base_dec(rrb_q);
  assign rrb    = rrb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_q <= '0;
      rrb_q  <= '0;
    end else if (clear) begin
      phys_q <= P_SIZE'(1);
      rrb_q  <= '0;
    end else if (step) begin
      rrb_q          <= wr_idx;
      phys_q[wr_idx] <= fill_bit;
    end
  end

  for (genvar g = 0; g < P_SIZE; g++) begin : g_logical
    assign pred_vec[g] = phys_q[phys_of(rrb_q, g)];
  end

endmodule

// File: rtl/swp_loop_branch.sv
module swp_loop_branch
  import swp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int P_SIZE = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      init_valid,
  input  logic [CNT_W-1:0]          init_iters,
  input  logic [CNT_W-1:0]          init_stages,
  input  logic                      br_valid,
  output logic                      br_taken,
  output logic [P_SIZE-1:0]         pred_vec,
  output logic [$clog2(P_SIZE)-1:0] rrb,
  output logic                      loop_done
);

  localparam int RRB_W = $clog2(P_SIZE);

  br_kind_e kind_w;
  logic     armed_w;
  logic     lc_nz_w;
  logic     esc_nz_w;
  logic     step_w;
  logic     fill_w;
  logic     exit_w;
  logic     taken_q;
  logic     done_q;

  swp_stage_counters #(.CNT_W(CNT_W)) u_counters (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_valid  (init_valid),
    .init_iters  (init_iters),
    .init_stages (init_stages),
    .br_valid    (br_valid),
    .kind        (kind_w),
    .armed       (armed_w),
    .lc_nonzero  (lc_nz_w),
    .esc_nonzero (esc_nz_w)
  );

  assign step_w = kind_rotates(kind_w);
  assign fill_w = kind_fill_bit(kind_w);
  assign exit_w = (kind_w == BK_EXIT);

  logic [RRB_W-1:0] rrb_w;

  swp_rot_pred_file #(.P_SIZE(P_SIZE)) u_preds (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (init_valid),
    .step     (step_w),
    .fill_bit (fill_w),
    .rrb      (rrb_w),
    .pred_vec (pred_vec)
  );

  assign rrb = rrb_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      taken_q <= step_w;
      done_q  <= exit_w;
    end
  end

  assign br_taken  = taken_q;
  assign loop_done = done_q;

endmodule

// File: rtl/swp_loop_branch_chk.sv
module swp_loop_branch_chk #(
  parameter int P_SIZE = 8,
  localparam int RRB_W = $clog2(P_SIZE)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_valid,
  input logic              br_valid,
  input logic              br_taken,
  input logic              loop_done,
  input logic [P_SIZE-1:0] pred_vec,
  input logic [RRB_W-1:0]  rrb,
  input logic              armed,
  input logic              lc_nz,
  input logic              esc_nz
);

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |=> (pred_vec == P_SIZE'(1)) && (rrb == '0) && !br_taken && !loop_done); // R1

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid && br_valid) |=> !br_taken && !loop_done); // R2

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && br_valid && !init_valid && lc_nz) |=> br_taken && pred_vec[0]); // R3

  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && br_valid && !init_valid && !lc_nz && esc_nz) |=> br_taken && !pred_vec[0]); // R4

  AST_EXIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && br_valid && !init_valid && !lc_nz && !esc_nz) |=> loop_done && !br_taken && !armed); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !loop_done); // R5

  AST_RRB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (rrb == RRB_W'($past(rrb) - RRB_W'(1)))); // R6

  AST_PRED_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (pred_vec[P_SIZE-1:1] == $past(pred_vec[P_SIZE-2:0]))); // R6

  AST_IGNORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && br_valid && !init_valid) |=> !br_taken && !loop_done && $stable(pred_vec) && $stable(rrb)); // R7

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({br_taken, loop_done})); // R5

  AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !br_taken && !loop_done); // R9

endmodule

bind swp_loop_branch swp_loop_branch_chk #(.P_SIZE(P_SIZE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_valid (init_valid),
  .br_valid   (br_valid),
  .br_taken   (br_taken),
  .loop_done  (loop_done),
  .pred_vec   (pred_vec),
  .rrb        (rrb),
  .armed      (armed_w),
  .lc_nz      (lc_nz_w),
  .esc_nz     (esc_nz_w)
);

// File: tb/test_swp_loop_branch.sv
module test_swp_loop_branch;

  localparam int CNT_W  = 16;
  localparam int P_SIZE = 8;
  localparam int RRB_W  = $clog2(P_SIZE);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              init_valid = 1'b0;
  logic [CNT_W-1:0]  init_iters = '0;
  logic [CNT_W-1:0]  init_stages = '0;
  logic              br_valid = 1'b0;
  logic              br_taken;
  logic [P_SIZE-1:0] pred_vec;
  logic [RRB_W-1:0]  rrb;
  logic              loop_done;

  always #10 clk = ~clk;  // 50 MHz

  swp_loop_branch #(.CNT_W(CNT_W), .P_SIZE(P_SIZE)) i_swp_loop_branch (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_iters(init_iters),
    .init_stages(init_stages), .br_valid(br_valid), .br_taken(br_taken),
    .pred_vec(pred_vec), .rrb(rrb), .loop_done(loop_done));

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model, kept in logical order.
  int                m_lc, m_esc;
  bit                m_armed;
  logic [RRB_W-1:0]  m_rrb;
  logic [P_SIZE-1:0] m_pv;
  logic              m_taken, m_done;
  string             m_req;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_step(bit init, int it, int st, bit br);
    m_taken = 1'b0;
    m_done  = 1'b0;
    if (init) begin
      m_lc = it; m_esc = st; m_armed = 1; m_rrb = '0; m_pv = P_SIZE'(1);
      m_req = br ? "R2" : "R1";
    end else if (!br) begin
      m_req = "R9";
    end else if (!m_armed) begin
      m_req = "R7";
    end else if (m_lc > 0) begin
      m_lc--; m_rrb = m_rrb - 1'b1; m_pv = {m_pv[P_SIZE-2:0], 1'b1}; m_taken = 1; m_req = "R3";
    end else if (m_esc > 0) begin
      m_esc--; m_rrb = m_rrb - 1'b1; m_pv = {m_pv[P_SIZE-2:0], 1'b0}; m_taken = 1; m_req = "R4";
    end else begin
      m_armed = 0; m_done = 1; m_req = "R5";
    end
  endfunction

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic cycle(bit init, int it, int st, bit br);
    init_valid  = init;
    init_iters  = CNT_W'(it);
    init_stages = CNT_W'(st);
    br_valid    = br;
    model_step(init, it, st, br);
    @(negedge clk);
    check(m_req, "br_taken",  32'(br_taken),  32'(m_taken));
    check(m_req, "loop_done", 32'(loop_done), 32'(m_done));
    check(m_req, "pred_vec",  32'(pred_vec),  32'(m_pv));
    check(m_taken ? "R6" : m_req, "rrb", 32'(rrb), 32'(m_rrb));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int taken_cnt;
    logic [3:0] exp_seq [7];
    void'($urandom(32'h5eed1));
    m_armed = 0; m_rrb = '0; m_pv = '0; m_lc = 0; m_esc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check("R10", "reset pred_vec", 32'(pred_vec), 0);
    check("R10", "reset rrb", 32'(rrb), 0);
    check("R10", "reset outputs", 32'({br_taken, loop_done}), 0);

    // R7: strobes before any initialise are ignored
    cycle(0, 0, 0, 1);
    cycle(0, 0, 0, 1);

    // R8: fixed 4 iterations / 4 stages sequence
    exp_seq = '{4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000};
    cycle(1, 3, 3, 0);
    check("R8", "seq0", 32'(pred_vec[3:0]), 32'(exp_seq[0]));
    taken_cnt = 0;
    for (int k = 1; k < 7; k++) begin
      cycle(0, 0, 0, 1);
      check("R8", "seq", 32'(pred_vec[3:0]), 32'(exp_seq[k]));
      taken_cnt += int'(br_taken);
    end
    cycle(0, 0, 0, 1);
    check("R8", "exit done", 32'(loop_done), 1);
    check("R8", "taken count N+S-2", taken_cnt, 6);
    // R7: strobes after exit are ignored
    cycle(0, 0, 0, 1);
    cycle(0, 0, 0, 1);

    // R5: single iteration, single stage falls through at once
    cycle(1, 0, 0, 0);
    cycle(0, 0, 0, 1);
    cycle(0, 0, 0, 0);

    // R2: initialise together with a branch strobe
    cycle(1, 2, 1, 0);
    cycle(0, 0, 0, 1);
    cycle(1, 5, 2, 1);
    cycle(0, 0, 0, 1);

    // R6: long loop wraps the rotation base
    cycle(1, 20, 3, 0);
    for (int k = 0; k < 26; k++) cycle(0, 0, 0, 1);

    // Constrained random mix
    for (int k = 0; k < 4000; k++) begin
      bit do_init, do_br;
      do_init = ($urandom_range(99) < 3);
      do_br   = ($urandom_range(99) < 80);
      cycle(do_init, $urandom_range(10), $urandom_range(5), do_br);
    end

    init_valid = 0; br_valid = 0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule